// File: doc/BRIEF.md
# Multimode Capture Compare Timer Cell

A single timer cell built around a 16-bit data register and a 16-bit equality comparator. The control register selects one of four modes: capture, compare, free timer or reset timer. In capture mode the register latches a reference time value on chosen edges of an input signal. In compare mode the cell flags a match between that reference value and the stored register. In timer mode the register counts on a hardware enable. Reset-timer mode counts the same way, but an event from the lower-numbered neighbour clears the count.

Every event of the cell can do two things. It can raise a sticky service-request flag, and it can drive its output pin with one of four actions: hold, set, clear or toggle. A one-shot option freezes the cell after its first event, and the next control write arms it again. Cells form a chain. The chain output tells the next, higher-numbered cell that an action is happening this cycle. A cell that is told to follow its chain input applies a neighbour's action to its own pin, which lets several cells build one multi-channel PWM pattern.

No interface of the block carries a data stream. Every pin is a plain control or status level sampled on each clock edge, so the block applies no back-pressure and has no valid/ready pair.

Top module: `tmr_cell`

## Requirements
- R1: After reset, `data_o`, `pin_o`, `sreq_o` and `evt_o` are 0, and `chain_vld_o` is 0 while the chain and event inputs are idle.
- R2: A write to address 1 loads `cfg_wdata` into the data register, and `data_o` shows it after that clock edge. The write takes priority over any hardware update in the same cycle.
- R3: Control address 0 holds the mode in bits [1:0], where 0 is capture. Bit 2 enables rising edges and bit 3 enables falling edges of `sig_i`. In capture mode each enabled edge latches `ref_i` into the data register and produces one event. Edges are judged against a registered copy of `sig_i`, so an input held steady produces no further events.
- R4: In compare mode (1), an event fires in every cycle in which `ref_i` equals the data register.
- R5: In timer mode (2), the register increments only in cycles where `cnt_en_i` is 1. On the step from 0xFFFF it wraps to 0x0000 and `evt_o` pulses for exactly one cycle.
- R6: In reset-timer mode (3), the register counts like timer mode, but `chain_vld_i` clears it to 0. The clear wins over increment and overflow and produces no event.
- R7: Control bits [5:4] select the pin action applied at the clock edge after an action: 0 hold, 1 set, 2 clear, 3 toggle. `pin_o` does not change without an action.
- R8: With control bit 6 set, each event sets `sreq_o`. A write to address 2 sets the flag with data bit 0 and clears it with bit 1. When both arrive together, set wins.
- R9: With control bit 7 set, the first event disarms the cell. From then on it neither latches, counts nor raises events until the next write to address 0.
- R10: `chain_vld_o` is 1 in the same cycle as the cell's own event, or when control bit 8 (follow) is set and `chain_vld_i` is 1. `chain_act_o` carries the cell's own action when it has an event, and `chain_act_i` otherwise. The pin applies whichever action `chain_act_o` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Write address: 0 control, 1 data, 2 flag set/clear |
| cfg_wdata | input | 16 | Write data |
| sig_i | input | 1 | Input signal for capture |
| ref_i | input | 16 | Reference time value |
| cnt_en_i | input | 1 | Hardware count enable |
| chain_vld_i | input | 1 | Action present from lower neighbour; reset source in reset-timer mode |
| chain_act_i | input | 2 | Action code from lower neighbour |
| data_o | output | 16 | Data register contents |
| evt_o | output | 1 | Registered one-cycle event pulse |
| pin_o | output | 1 | Output pin |
| sreq_o | output | 1 | Sticky service-request flag |
| chain_vld_o | output | 1 | Action present for upper neighbour |
| chain_act_o | output | 2 | Action code for upper neighbour |

## Verification
A corrupt data register shows on `data_o` at the next edge. In compare mode it also shows as a missing or misplaced `evt_o` pulse. A wrong edge-history bit causes a spurious or missed capture within one cycle of the next change on `sig_i`. A stuck arm flag either keeps a one-shot cell firing or silences a re-armed one, and this shows at the next matching event. A wrong pin action appears on `pin_o` one edge after the action, and on the combinational chain outputs in the same cycle.

// File: rtl/tmr_cell_pkg.sv
package tmr_cell_pkg;

  typedef enum logic [1:0] {
    MD_CAPTURE = 2'd0,
    MD_COMPARE = 2'd1,
    MD_TIMER   = 2'd2,
    MD_RSTTMR  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    PA_HOLD = 2'd0,
    PA_SET  = 2'd1,
    PA_CLR  = 2'd2,
    PA_TGL  = 2'd3
  } pin_act_e;

  typedef struct packed {
    logic     follow;
    logic     oneshot;
    logic     sr_en;
    pin_act_e act;
    logic     fall;
    logic     rise;
    mode_e    mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd2;

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic rise_en,
  input  logic fall_en,
  output logic hit_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign hit_o = (rise_en & sig_i & ~sig_q) | (fall_en & ~sig_i & sig_q);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_cell_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode,
  input  logic          armed,
  input  logic          sw_we,
  input  logic [DW-1:0] sw_data,
  input  logic [DW-1:0] ref_i,
  input  logic          cnt_en_i,
  input  logic          clr_i,
  input  logic          cap_hit,
  output logic [DW-1:0] data_o,
  output logic          evt_o
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  logic [DW-1:0] data_q, data_d;
  logic          ev;
  logic          at_top;

  assign at_top = &data_q;

  always_comb begin
    data_d = data_q;
    ev     = 1'b0;
    if (armed) begin
      unique case (mode)
        MD_CAPTURE: begin
          if (cap_hit) begin
            data_d = ref_i;
            ev     = 1'b1;
          end
        end
        MD_COMPARE: ev = (ref_i == data_q);
        MD_TIMER: begin
          if (cnt_en_i) begin
            data_d = data_q + ONE;
            ev     = at_top;
          end
        end
        MD_RSTTMR: begin
          if (clr_i) begin
            data_d = '0;
          end else if (cnt_en_i) begin
            data_d = data_q + ONE;
            ev     = at_top;
          end
        end
        default: ;
      endcase
    end
    if (sw_we) data_d = sw_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_o = data_q;
  assign evt_o  = ev;
endmodule

// File: rtl/tmr_pin_drv.sv
module tmr_pin_drv
  import tmr_cell_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     apply,
  input  pin_act_e act,
  input  logic     sr_hw_set,
  input  logic     sr_sw_set,
  input  logic     sr_sw_clr,
  output logic     pin_o,
  output logic     sreq_o
);
  logic pin_q, sreq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else if (apply) begin
      unique case (act)
        PA_SET:  pin_q <= 1'b1;
        PA_CLR:  pin_q <= 1'b0;
        PA_TGL:  pin_q <= ~pin_q;
        default: pin_q <= pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       sreq_q <= 1'b0;
    else if (sr_hw_set || sr_sw_set)  sreq_q <= 1'b1;
    else if (sr_sw_clr)               sreq_q <= 1'b0;
  end

  assign pin_o  = pin_q;
  assign sreq_o = sreq_q;
endmodule

// File: rtl/tmr_cell.sv
module tmr_cell
  import tmr_cell_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic              sig_i,
  input  logic [DW-1:0]     ref_i,
  input  logic              cnt_en_i,
  input  logic              chain_vld_i,
  input  logic [1:0]        chain_act_i,
  output logic [DW-1:0]     data_o,
  output logic              evt_o,
  output logic              pin_o,
  output logic              sreq_o,
  output logic              chain_vld_o,
  output logic [1:0]        chain_act_o
);
  ctrl_t    ctrl_q;
  logic     armed_q;
  logic     evt_q;
  logic     ctrl_wr, data_wr, flag_wr;
  logic     cap_hit;
  logic     own_evt;
  logic     pin_apply;
  pin_act_e pin_act;

  assign ctrl_wr = cfg_we && (cfg_addr == A_CTRL);
  assign data_wr = cfg_we && (cfg_addr == A_DATA);
  assign flag_wr = cfg_we && (cfg_addr == A_FLAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b1;
      evt_q   <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      if (ctrl_wr)                           armed_q <= 1'b1;
      else if (own_evt && ctrl_q.oneshot)    armed_q <= 1'b0;
      evt_q <= own_evt;
    end
  end

  tmr_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig_i   (sig_i),
    .rise_en (ctrl_q.rise),
    .fall_en (ctrl_q.fall),
    .hit_o   (cap_hit)
  );

  tmr_datapath #(.DW(DW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (ctrl_q.mode),
    .armed    (armed_q),
    .sw_we    (data_wr),
    .sw_data  (cfg_wdata),
    .ref_i    (ref_i),
    .cnt_en_i (cnt_en_i),
    .clr_i    (chain_vld_i),
    .cap_hit  (cap_hit),
    .data_o   (data_o),
    .evt_o    (own_evt)
  );

  assign pin_apply   = own_evt | (ctrl_q.follow & chain_vld_i);
  assign pin_act     = own_evt ? ctrl_q.act : pin_act_e'(chain_act_i);
  assign chain_vld_o = pin_apply;
  assign chain_act_o = pin_act;

  tmr_pin_drv u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .apply     (pin_apply),
    .act       (pin_act),
    .sr_hw_set (own_evt & ctrl_q.sr_en),
    .sr_sw_set (flag_wr & cfg_wdata[0]),
    .sr_sw_clr (flag_wr & cfg_wdata[1]),
    .pin_o     (pin_o),
    .sreq_o    (sreq_o)
  );

  assign evt_o = evt_q;
endmodule

// File: rtl/tmr_cell_chk.sv
module tmr_cell_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_addr,
  input logic          set_bit,
  input logic          cnt_en_i,
  input logic          chain_vld_i,
  input logic [DW-1:0] data_o,
  input logic          evt_o,
  input logic          pin_o,
  input logic          sreq_o,
  input logic          chain_vld_o,
  input logic [1:0]    mode,
  input logic          armed,
  input logic          pin_apply
);
  logic sw_data_wr, sw_ctrl_wr;
  assign sw_data_wr = cfg_we && (cfg_addr == 2'd1);
  assign sw_ctrl_wr = cfg_we && (cfg_addr == 2'd0);

  // R7
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_apply |=> $stable(pin_o));

  // R8
  sreq_setwin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 2'd2 && set_bit) |=> sreq_o);

  // R5
  timer_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode == 2'd2 && cnt_en_i && (&data_o) && !sw_data_wr)
      |=> (data_o == '0 && evt_o));

  // R6
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && mode == 2'd3 && chain_vld_i && !sw_data_wr)
      |=> (data_o == '0 && !evt_o));

  // R9
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !sw_ctrl_wr) |=> !evt_o);

  // R10
  evt_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> $past(chain_vld_o));
endmodule

bind tmr_cell tmr_cell_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .set_bit     (cfg_wdata[0]),
  .cnt_en_i    (cnt_en_i),
  .chain_vld_i (chain_vld_i),
  .data_o      (data_o),
  .evt_o       (evt_o),
  .pin_o       (pin_o),
  .sreq_o      (sreq_o),
  .chain_vld_o (chain_vld_o),
  .mode        (ctrl_q.mode),
  .armed       (armed_q),
  .pin_apply   (pin_apply)
);

// File: tb/test_tmr_cell.sv
module test_tmr_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        sig_i = 1'b0;
  logic [15:0] ref_i = '0;
  logic        cnt_en_i = 1'b0;
  logic        chain_vld_i = 1'b0;
  logic [1:0]  chain_act_i = '0;
  logic [15:0] data_o;
  logic        evt_o, pin_o, sreq_o, chain_vld_o;
  logic [1:0]  chain_act_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tmr_cell i_tmr_cell (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .sig_i(sig_i), .ref_i(ref_i), .cnt_en_i(cnt_en_i),
    .chain_vld_i(chain_vld_i), .chain_act_i(chain_act_i), .data_o(data_o),
    .evt_o(evt_o), .pin_o(pin_o), .sreq_o(sreq_o), .chain_vld_o(chain_vld_o),
    .chain_act_o(chain_act_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // caller stands at a negedge; returns at the negedge after the write edge
  task automatic wr(logic [1:0] a, logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [15:0] cw(int md, bit ri, bit fa, int act,
                                     bit sr, bit os, bit fol);
    return {7'd0, fol, os, sr, act[1:0], fa, ri, md[1:0]};
  endfunction

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] exp_d;
    logic        exp_pin;
    logic        prev_sig;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 data", data_o, 0); chk("R1 pin", pin_o, 0);
    chk("R1 sreq", sreq_o, 0); chk("R1 evt", evt_o, 0);
    chk("R1 chain", chain_vld_o, 0);

    // timer sweep with gapped enable
    wr(2'd1, 16'hFFF0);
    chk("R2 data write", data_o, 16'hFFF0);
    wr(2'd0, cw(2, 0, 0, 3, 1, 0, 0));
    exp_d = 16'hFFF0; exp_pin = 1'b0;
    for (int i = 0; i < 40; i++) begin
      bit en, ovf;
      en = (i % 3) != 0;
      cnt_en_i = en;
      ovf = en && (exp_d == 16'hFFFF);
      @(negedge clk);
      if (en) exp_d = exp_d + 16'd1;
      if (ovf) exp_pin = ~exp_pin;
      chk("R5 count", data_o, exp_d);
      chk("R5 wrap pulse", evt_o, ovf);
      chk("R7 toggle", pin_o, exp_pin);
    end
    cnt_en_i = 1'b0;
    chk("R8 set by event", sreq_o, 1);
    wr(2'd2, 16'd2); chk("R8 clear", sreq_o, 0);
    wr(2'd2, 16'd3); chk("R8 set wins", sreq_o, 1);
    wr(2'd2, 16'd2); chk("R8 clear again", sreq_o, 0);

    // compare sweeps with clear, then set, then hold actions
    wr(2'd1, 16'h1234);
    for (int a = 2; a >= 0; a--) begin
      wr(2'd0, cw(1, 0, 0, a, 0, 0, 0));
      for (int r = 16'h1230; r <= 16'h1238; r++) begin
        bit eq;
        ref_i = r[15:0];
        eq = (r == 16'h1234);
        #1 chk("R10 chain with own event", chain_vld_o, eq);
        if (eq) chk("R10 own action out", chain_act_o, a);
        @(negedge clk);
        chk("R4 compare event", evt_o, eq);
        if (eq && a == 2) exp_pin = 1'b0;
        if (eq && a == 1) exp_pin = 1'b1;
        chk("R7 pin action", pin_o, exp_pin);
      end
      ref_i = '0;
    end

    // one-shot: three matching cycles give one toggle
    wr(2'd0, cw(1, 0, 0, 3, 0, 1, 0));
    ref_i = 16'h1234;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 0) exp_pin = ~exp_pin;
      chk("R9 single event", evt_o, k == 0);
      chk("R9 single toggle", pin_o, exp_pin);
    end
    ref_i = '0;
    wr(2'd0, cw(1, 0, 0, 3, 0, 1, 0));
    ref_i = 16'h1234;
    @(negedge clk);
    exp_pin = ~exp_pin;
    chk("R9 re-armed event", evt_o, 1);
    chk("R9 re-armed toggle", pin_o, exp_pin);
    ref_i = '0;

    // capture: rising, falling, both
    exp_d = 16'h1234; prev_sig = 1'b0;
    for (int es = 1; es <= 3; es++) begin
      wr(2'd0, cw(0, es[0], es[1], 0, 0, 0, 0));
      for (int k = 0; k < 8; k++) begin
        bit s, hit;
        s = ((k >> 1) & 1) != 0;
        hit = (s && !prev_sig && es[0]) || (!s && prev_sig && es[1]);
        sig_i = s;
        ref_i = 16'(es * 256 + k);
        @(negedge clk);
        if (hit) exp_d = 16'(es * 256 + k);
        prev_sig = s;
        chk("R3 capture value", data_o, exp_d);
        chk("R3 capture event", evt_o, hit);
      end
    end
    sig_i = 1'b0; ref_i = '0;
    @(negedge clk);

    // reset timer
    wr(2'd1, 16'hFFFE);
    wr(2'd0, cw(3, 0, 0, 0, 0, 0, 0));
    exp_d = 16'hFFFE;
    for (int i = 0; i < 10; i++) begin
      bit clr, ovf;
      clr = (i == 1) || (i == 5);
      cnt_en_i = 1'b1; chain_vld_i = clr;
      ovf = !clr && exp_d == 16'hFFFF;
      @(negedge clk);
      if (clr) exp_d = '0; else exp_d = exp_d + 16'd1;
      chk("R6 reset timer value", data_o, exp_d);
      chk("R6 no event on clear", evt_o, ovf);
    end
    cnt_en_i = 1'b0; chain_vld_i = 1'b0;

    // chain follow
    wr(2'd0, cw(1, 0, 0, 3, 0, 0, 1));
    chain_vld_i = 1'b1; chain_act_i = 2'd1;
    #1 chk("R10 forward valid", chain_vld_o, 1);
    chk("R10 forward action", chain_act_o, 1);
    @(negedge clk); chk("R10 follow set", pin_o, 1);
    chain_act_i = 2'd2;
    @(negedge clk); chk("R10 follow clear", pin_o, 0);
    chain_act_i = 2'd1; ref_i = exp_d;
    #1 chk("R10 own action wins", chain_act_o, 3);
    @(negedge clk); chk("R10 own toggle", pin_o, 1);
    ref_i = '0;
    wr(2'd0, cw(1, 0, 0, 3, 0, 0, 0));
    chain_act_i = 2'd2;
    #1 chk("R10 no follow", chain_vld_o, 0);
    @(negedge clk); chk("R10 pin kept", pin_o, 1);
    chain_vld_i = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule